// File: doc/BRIEF.md
# Latched Status Interrupt Controller

This block gathers three per-channel health inputs (reference present, signal present, self-test pass) and turns them into status words a host reads over a simple register port. The live inputs arrive already qualified. The block samples them once per scan period, a parameterised number of clock cycles. When any bit moves from its good state to its fail state, the block freezes the status words the host sees and raises an interrupt.

The host sees a frozen snapshot until it reads one of the status words. Changes that arrive in the meantime are kept in a background copy, which is refreshed at every scan. A status read drops the freeze and loads the background copy into the visible words on the next clock edge. After that the visible words follow the scan again.

Interrupts carry a host-programmed priority level and an 8-bit vector. A failure uses one vector and an external alert event uses the other. A failure is always presented ahead of an alert. Each pending cause is cleared by its own acknowledge. A soft reset clears the status, the pending causes and the level register.

Top module: `status_irq_ctrl`

## Requirements
- R1: While not frozen, at each scan tick the visible status words take the live inputs. Bit value 1 means present or OK and 0 means loss or fail.
- R2: At a scan tick where any bit of the live inputs is 0 and the same bit of the background copy is 1, the visible words take the live inputs and then hold still until a status read.
- R3: A read of address 0, 1 or 2 while frozen ends the freeze. From the next cycle the visible words equal the background copy captured at the latest scan tick.
- R4: A fail transition with a nonzero level raises `irq`. It presents the failure vector, and `irq_lvl` equals the level, clamped to 7 for level values 8 to 255.
- R5: With level 0 no interrupt is raised. Writing 0 to the level register drops any pending cause.
- R6: An acknowledge clears the pending failure. A later fail transition, including one seen against the background copy while frozen, raises a new interrupt.
- R7: An `alert_evt` pulse with a nonzero level raises an interrupt with the alert vector. When both causes are pending, the failure vector is shown. An acknowledge then clears only the failure, and the alert stays pending until a second acknowledge.
- R8: `soft_rst` clears the visible words, the background copy, the freeze, both pending causes and the level register. The two vectors keep their values.
- R9: The register map, in bits [NCH-1:0], zero-extended, is: address 0 reference, 1 signal, 2 self-test, 3 level, 4 failure vector, 5 alert vector. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| ref_ok | input | NCH | Live reference-present per channel |
| sig_ok | input | NCH | Live signal-present per channel |
| tst_ok | input | NCH | Live self-test pass per channel |
| alert_evt | input | 1 | Alert event pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Priority level while irq is high |
| irq_vec | output | 8 | Vector of the cause being presented |

## Verification
The reference word is swept over every ordered pair of 4-bit patterns. Each pair separates pure improvements, which must only update the visible word, from any loss, which must freeze the word and interrupt. For each freezing pair the bench then returns to the first pattern before reading. This shows that the read returns the frozen value and the following read returns the background value. Directed sequences cover a second fail seen while frozen after an acknowledge, level clamping and masking, alert and failure arriving together, and soft reset keeping the vectors.

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl #(
  parameter int NCH        = 4,
  parameter int SCAN_TICKS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic [NCH-1:0] ref_ok,
  input  logic [NCH-1:0] sig_ok,
  input  logic [NCH-1:0] tst_ok,
  input  logic           alert_evt,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [2:0]     addr,
  input  logic [7:0]     wdata,
  output logic [15:0]    rdata,
  input  logic           irq_ack,
  output logic           irq,
  output logic [2:0]     irq_lvl,
  output logic [7:0]     irq_vec
);
  localparam int W  = 3 * NCH;
  localparam int CW = (SCAN_TICKS > 2) ? $clog2(SCAN_TICKS) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  live, vis, bkg;
  logic          frozen, fail_pend, alert_pend;
  logic [7:0]    lvl, vec_fail, vec_alert;

  assign live = {tst_ok, sig_ok, ref_ok};

  wire tick    = (cnt == CW'(SCAN_TICKS - 1));
  wire err     = tick && |(bkg & ~live);
  wire rd_stat = rd_en && (addr < 3'd3);
  wire en      = (lvl != 8'd0);
  wire lvl_clr = wr_en && (addr == 3'd3) && (wdata == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      vis        <= '0;
      bkg        <= '0;
      frozen     <= 1'b0;
      fail_pend  <= 1'b0;
      alert_pend <= 1'b0;
      lvl        <= 8'd0;
      vec_fail   <= 8'd0;
      vec_alert  <= 8'd0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (soft_rst) begin
        vis        <= '0;
        bkg        <= '0;
        frozen     <= 1'b0;
        fail_pend  <= 1'b0;
        alert_pend <= 1'b0;
        lvl        <= 8'd0;
      end else begin
        if (tick) begin
          bkg <= live;
          if (!frozen) vis <= live;
          if (err) frozen <= 1'b1;
        end
        if (rd_stat && frozen) begin
          frozen <= 1'b0;
          vis    <= bkg;
        end
        if (irq_ack) begin
          if (fail_pend) fail_pend  <= 1'b0;
          else           alert_pend <= 1'b0;
        end
        if (err && en)       fail_pend  <= 1'b1;
        if (alert_evt && en) alert_pend <= 1'b1;
        if (wr_en) begin
          case (addr)
            3'd3:    lvl       <= wdata;
            3'd4:    vec_fail  <= wdata;
            3'd5:    vec_alert <= wdata;
            default: ;
          endcase
        end
        if (lvl_clr) begin
          fail_pend  <= 1'b0;
          alert_pend <= 1'b0;
        end
      end
    end
  end

  assign irq     = fail_pend | alert_pend;
  assign irq_lvl = !irq ? 3'd0 : (lvl > 8'd7) ? 3'd7 : lvl[2:0];
  assign irq_vec = fail_pend ? vec_fail : vec_alert;

  always_comb begin
    case (addr)
      3'd0:    rdata = 16'(vis[NCH-1:0]);
      3'd1:    rdata = 16'(vis[2*NCH-1:NCH]);
      3'd2:    rdata = 16'(vis[W-1:2*NCH]);
      3'd3:    rdata = {8'd0, lvl};
      3'd4:    rdata = {8'd0, vec_fail};
      3'd5:    rdata = {8'd0, vec_alert};
      default: rdata = 16'd0;
    endcase
  end

  AST_FOLLOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frozen && !rd_stat && !soft_rst) |=> vis == $past(live)); // R1
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rd_stat && !soft_rst) |=> $stable(vis)); // R2
  AST_READ_LOADS_BKG: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && rd_stat && !soft_rst) |=> (!frozen && vis == $past(bkg))); // R3
  AST_LVL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 8'd0) |-> !irq); // R5
  AST_ACK_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && fail_pend && !err && !soft_rst) |=> !fail_pend); // R6
  AST_FAIL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pend && alert_pend) |-> irq_vec == vec_fail); // R7
  AST_ALERT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && fail_pend && alert_pend && !soft_rst && !lvl_clr) |=> alert_pend); // R7
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && !frozen && lvl == 8'd0)); // R8
endmodule

// File: tb/status_irq_ctrl_tb.sv
module status_irq_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int S   = 8;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [NCH-1:0] ref_ok = '1, sig_ok = '1, tst_ok = '1;
  logic alert_evt = 1'b0, wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [15:0] rdata;
  logic irq;
  logic [2:0] irq_lvl;
  logic [7:0] irq_vec;
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  status_irq_ctrl #(.NCH(NCH), .SCAN_TICKS(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ref_ok(ref_ok), .sig_ok(sig_ok),
    .tst_ok(tst_ok), .alert_evt(alert_evt), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq), .irq_lvl(irq_lvl),
    .irq_vec(irq_vec));

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sync();
    do @(negedge clk); while (cyc % S != 0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic settle(input logic [NCH-1:0] r, input logic [NCH-1:0] s, input logic [NCH-1:0] t);
    logic [15:0] d;
    ref_ok = r; sig_ok = s; tst_ok = t;
    sync(); rd(3'd0, d); ack(); ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 reset irq", {15'd0, irq}, 16'd0);
    rd(3'd0, d); check("R9 reset ref word", d, 16'd0);
    wr(3'd3, 8'd3); wr(3'd4, 8'h5A); wr(3'd5, 8'hC3);
    settle('1, '1, '1);

    // Sweep every ordered pair of reference patterns
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        settle(NCH'(a), '1, '1);
        ref_ok = NCH'(b);
        sync();
        e = |(NCH'(a) & ~NCH'(b));
        #1;
        check(e ? "R2 irq on loss" : "R1 no irq on gain", {15'd0, irq}, {15'd0, e});
        if (e) begin
          check("R4 level", {13'd0, irq_lvl}, 16'd3);
          check("R4 fail vector", {8'd0, irq_vec}, 16'h5A);
          ref_ok = NCH'(a);
          sync();
          rd(3'd0, d); check("R2 frozen value", d, 16'(b));
          rd(3'd0, d); check("R3 background loaded", d, 16'(a));
          ack();
        end else begin
          rd(3'd0, d); check("R1 follows live", d, 16'(b));
        end
      end
    end

    // R9 map and encoding
    settle('1, '1, '1);
    sig_ok = 4'b0110; sync();
    rd(3'd1, d); check("R9 signal word", d, 16'h0006);
    rd(3'd2, d); check("R9 test word", d, 16'h000F);
    rd(3'd3, d); check("R9 level reg", d, 16'h0003);
    rd(3'd4, d); check("R9 fail vector reg", d, 16'h005A);
    rd(3'd5, d); check("R9 alert vector reg", d, 16'h00C3);
    rd(3'd6, d); check("R9 unused address", d, 16'h0000);
    ack();

    // R6 new interrupt after ack, seen while frozen
    settle('1, '1, '1);
    tst_ok = 4'b0111; sync(); #1;
    check("R6 first fail irq", {15'd0, irq}, 16'd1);
    ack(); #1;
    check("R6 ack clears", {15'd0, irq}, 16'd0);
    tst_ok = 4'b0011; sync(); #1;
    check("R6 second fail irq while frozen", {15'd0, irq}, 16'd1);
    rd(3'd2, d); check("R2 test word frozen", d, 16'h0007);
    ack();

    // R4 clamp, R5 masking
    settle('1, '1, '1);
    wr(3'd3, 8'd9);
    ref_ok = 4'b1110; sync(); #1;
    check("R4 clamped level", {13'd0, irq_lvl}, 16'd7);
    wr(3'd3, 8'd0); #1;
    check("R5 write zero drops irq", {15'd0, irq}, 16'd0);
    settle('1, '1, '1);
    ref_ok = 4'b0000; sync(); #1;
    check("R5 masked fail", {15'd0, irq}, 16'd0);

    // R7 alert and priority
    settle('1, '1, '1);
    wr(3'd3, 8'd5);
    alert_evt = 1'b1; @(negedge clk); alert_evt = 1'b0; #1;
    check("R7 alert irq", {15'd0, irq}, 16'd1);
    check("R7 alert vector", {8'd0, irq_vec}, 16'hC3);
    ref_ok = 4'b1011; sync(); #1;
    check("R7 fail shown first", {8'd0, irq_vec}, 16'h5A);
    ack(); #1;
    check("R7 alert still pending", {15'd0, irq}, 16'd1);
    check("R7 alert vector after ack", {8'd0, irq_vec}, 16'hC3);
    ack(); #1;
    check("R7 second ack clears", {15'd0, irq}, 16'd0);

    // R8 soft reset
    settle('1, '1, '1);
    ref_ok = 4'b0001; sync();
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0; #1;
    check("R8 irq cleared", {15'd0, irq}, 16'd0);
    rd(3'd0, d); check("R8 status cleared", d, 16'd0);
    rd(3'd3, d); check("R8 level cleared", d, 16'd0);
    rd(3'd4, d); check("R8 fail vector kept", d, 16'h005A);
    rd(3'd5, d); check("R8 alert vector kept", d, 16'h00C3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule